// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a calendar clock that shares a 32K x 8 byte-wide memory address space with an ordinary RAM. Its eight timekeeping bytes take up the top eight addresses. The host reaches them with the same address, data, chip-enable, output-enable and write-enable signalling it uses for the RAM, so software reads and sets the time with plain byte loads and stores. Every other address is passed through to an external RAM port.

The clock keeps century, year, month, date, day-of-week, hours, minutes and seconds, all in packed BCD. A one-cycle pulse on the tick input advances the time by one second. Carries ripple from seconds up to century within that same edge. February gets 29 days in leap years, including the correct turn at each century boundary.

Top module: `bcd_rtc_map`

## Requirements
- R1: Offsets 0x7FF8 through 0x7FFF hold, in this order, century, year, month, date, day-of-week, hours, minutes and seconds. With ce_n=0, oe_n=0 and we_n=1, rdata shows the addressed register in the same cycle, with no clock edge needed.
- R2: A write (ce_n=0, we_n=0, address at or above 0x7FF8) loads wdata into the addressed register on the rising edge. If a tick arrives on the same edge, the written value replaces that register's tick update, and the other registers still advance.
- R3: On a tick, seconds count in BCD and wrap from 0x59 to 0x00. A seconds wrap bumps minutes, and minutes also wrap from 0x59 to 0x00.
- R4: Hours use the 24-hour format. A minutes wrap at hour 0x23 takes hours to 0x00 and advances both the date and the day-of-week.
- R5: Day-of-week counts 1 to 7, and a day change at 7 returns it to 1.
- R6: The date wraps to 0x01 after the last day of the month: 0x31 for months 01, 03, 05, 07, 08, 10 and 12, and 0x30 for 04, 06, 09 and 11. The wrap advances the month.
- R7: February ends at 0x29 when the BCD year is divisible by four. For year 00 the century must be divisible by four instead. In every other year February ends at 0x28.
- R8: Month wraps from 0x12 to 0x01 and advances the year. Year wraps from 0x99 to 0x00 and advances the century. Century wraps from 0x99 to 0x00.
- R9: When the address is below 0x7FF8, rdata equals ram_rdata and ram_ce_n follows ce_n. When the address is at or above 0x7FF8, ram_ce_n is held at 1.
- R10: After reset the registers read century 0x20, year 0x00, month 0x01, date 0x01, day 0x01, and 0x00 for hours, minutes and seconds.
- R11: With no tick and no clock-register write, all eight registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: a clock register or the RAM data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable: low for writes, high for reads |
| bus_oe | output | 1 | High when a read drives the data bus |
| ram_ce_n | output | 1 | RAM chip enable, held high over the clock window |
| ram_oe_n | output | 1 | RAM output enable |
| ram_we_n | output | 1 | RAM write enable |
| ram_rdata | input | 8 | Read data from the RAM |

## Verification
Reads are combinational, so the bench sets the address and samples rdata 1 ns later in the same cycle. Writes and ticks take effect on the next rising edge. The bench therefore drives them at a falling edge, updates its own model at the rising edge, and samples 1 ns after that edge. A write and a tick on the same edge are checked together to confirm that the write wins for the addressed register and that the carry still reaches the other registers.

// File: rtl/bcd_rtc_map.sv
module bcd_rtc_map #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  output logic          bus_oe,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  input  logic [7:0]    ram_rdata
);

  logic [7:0] cen, yr, mon, dat, dow, hr, mn, sc;
  logic [7:0] n_cen, n_yr, n_mon, n_dat, n_dow, n_hr, n_mn, n_sc;
  logic [7:0] mdays, rsel;
  logic       c_s, c_m, c_h, c_d, c_mo, c_y, leap;
  logic [1:0] ym4, cm4;

  wire       rtc_sel = &addr[AW-1:3];
  wire [2:0] idx     = addr[2:0];
  wire       wr      = rtc_sel && !ce_n && !we_n;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  // value mod 4 of a BCD byte: (2*tens + units) mod 4
  assign ym4  = {yr[4], 1'b0} + yr[1:0];
  assign cm4  = {cen[4], 1'b0} + cen[1:0];
  assign leap = (yr == 8'h00) ? (cm4 == 2'd0) : (ym4 == 2'd0);

  always_comb begin
    case (mon)
      8'h02:                      mdays = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mdays = 8'h30;
      default:                    mdays = 8'h31;
    endcase
  end

  assign c_s  = tick_1hz && (sc == 8'h59);
  assign c_m  = c_s && (mn == 8'h59);
  assign c_h  = c_m && (hr == 8'h23);
  assign c_d  = c_h && (dat == mdays);
  assign c_mo = c_d && (mon == 8'h12);
  assign c_y  = c_mo && (yr == 8'h99);

  assign n_sc  = tick_1hz ? (c_s ? 8'h00 : bcd_inc(sc)) : sc;
  assign n_mn  = c_s  ? (c_m ? 8'h00 : bcd_inc(mn)) : mn;
  assign n_hr  = c_m  ? (c_h ? 8'h00 : bcd_inc(hr)) : hr;
  assign n_dow = c_h  ? ((dow == 8'h07) ? 8'h01 : bcd_inc(dow)) : dow;
  assign n_dat = c_h  ? (c_d ? 8'h01 : bcd_inc(dat)) : dat;
  assign n_mon = c_d  ? (c_mo ? 8'h01 : bcd_inc(mon)) : mon;
  assign n_yr  = c_mo ? (c_y ? 8'h00 : bcd_inc(yr)) : yr;
  assign n_cen = c_y  ? ((cen == 8'h99) ? 8'h00 : bcd_inc(cen)) : cen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cen <= 8'h20; yr <= 8'h00; mon <= 8'h01; dat <= 8'h01;
      dow <= 8'h01; hr <= 8'h00; mn  <= 8'h00; sc  <= 8'h00;
    end else begin
      cen <= n_cen; yr <= n_yr; mon <= n_mon; dat <= n_dat;
      dow <= n_dow; hr <= n_hr; mn  <= n_mn;  sc  <= n_sc;
      if (wr) begin
        case (idx)
          3'd0: cen <= wdata;
          3'd1: yr  <= wdata;
          3'd2: mon <= wdata;
          3'd3: dat <= wdata;
          3'd4: dow <= wdata;
          3'd5: hr  <= wdata;
          3'd6: mn  <= wdata;
          default: sc <= wdata;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      3'd0: rsel = cen;
      3'd1: rsel = yr;
      3'd2: rsel = mon;
      3'd3: rsel = dat;
      3'd4: rsel = dow;
      3'd5: rsel = hr;
      3'd6: rsel = mn;
      default: rsel = sc;
    endcase
  end

  assign rdata    = rtc_sel ? rsel : ram_rdata;
  assign bus_oe   = !ce_n && !oe_n && we_n;
  assign ram_ce_n = ce_n || rtc_sel;
  assign ram_oe_n = oe_n;
  assign ram_we_n = we_n;

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr && sc == 8'h59) |=> (sc == 8'h00));

  assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr && sc == 8'h59 && mn == 8'h59 && hr == 8'h23) |=> (hr == 8'h00));

  assert_dow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr && sc == 8'h59 && mn == 8'h59 && hr == 8'h23 && dow == 8'h07)
      |=> (dow == 8'h01));

  assert_sec_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 3'd7) |=> (sc == $past(wdata)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !wr) |=> $stable({cen, yr, mon, dat, dow, hr, mn, sc}));

  assert_ram_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_sel |-> ram_ce_n);

endmodule

// File: tb/bcd_rtc_map_test.sv
`timescale 1ns/100ps
module bcd_rtc_map_test;
  logic        clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0, ram_rdata = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  rdata;
  logic        bus_oe, ram_ce_n, ram_oe_n, ram_we_n;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m [8];

  bcd_rtc_map uut (.*);

  always #5 clk = ~clk;

  function automatic int b2i(logic [7:0] b); return b[7:4] * 10 + b[3:0]; endfunction
  function automatic logic [7:0] i2b(int v); return 8'((v / 10) * 16 + v % 10); endfunction

  function automatic int dim(int mo, int y, int c);
    bit lp = (y == 0) ? (c % 4 == 0) : (y % 4 == 0);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    int c = b2i(m[0]), y = b2i(m[1]), mo = b2i(m[2]), dt = b2i(m[3]);
    int dw = b2i(m[4]), h = b2i(m[5]), mi = b2i(m[6]), s = b2i(m[7]);
    s++;
    if (s == 60) begin s = 0; mi++;
      if (mi == 60) begin mi = 0; h++;
        if (h == 24) begin h = 0; dw = (dw == 7) ? 1 : dw + 1; dt++;
          if (dt > dim(mo, y, c)) begin dt = 1; mo++;
            if (mo > 12) begin mo = 1; y++;
              if (y > 99) begin y = 0; c = (c == 99) ? 0 : c + 1; end
            end
          end
        end
      end
    end
    m[0] = i2b(c); m[1] = i2b(y); m[2] = i2b(mo); m[3] = i2b(dt);
    m[4] = i2b(dw); m[5] = i2b(h); m[6] = i2b(mi); m[7] = i2b(s);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(bit tk, bit w, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    tick_1hz = tk;
    if (w) begin ce_n = 0; we_n = 0; addr = 15'h7FF8 + 15'(a); wdata = d; end
    @(posedge clk); #1;
    if (tk) model_tick();
    if (w) m[a] = d;
    tick_1hz = 0; ce_n = 1; we_n = 1;
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 8; i++) begin
      addr = 15'h7FF8 + 15'(i); ce_n = 0; oe_n = 0; we_n = 1; #1;
      chk($sformatf("%s reg%0d", tag, i), rdata, m[i]);
    end
    ce_n = 1; oe_n = 1;
  endtask

  task automatic set_time(int c, int y, int mo, int dt, int dw, int h, int mi, int s);
    step(0, 1, 0, i2b(c));  step(0, 1, 1, i2b(y));  step(0, 1, 2, i2b(mo));
    step(0, 1, 3, i2b(dt)); step(0, 1, 4, i2b(dw)); step(0, 1, 5, i2b(h));
    step(0, 1, 6, i2b(mi)); step(0, 1, 7, i2b(s));
  endtask

  function automatic int rnd_field(int i);
    case (i)
      0, 1: return $urandom % 100;
      2: return 1 + $urandom % 12;
      3: return 1 + $urandom % 28;
      4: return 1 + $urandom % 7;
      5: return $urandom % 24;
      default: return 50 + $urandom % 10;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m = '{8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check_all("R10 reset");

    set_time(47, 63, 9, 14, 3, 12, 34, 56);
    check_all("R1 R2 write/readback");

    set_time(19, 99, 12, 31, 7, 23, 59, 59);
    step(1, 0, 0, 0);
    check_all("R8 R4 R5 R3 1999 to 2000");

    set_time(20, 24, 2, 28, 2, 23, 59, 59);
    step(1, 0, 0, 0); check_all("R7 leap 2024 Feb29");
    set_time(20, 24, 2, 29, 2, 23, 59, 59);
    step(1, 0, 0, 0); check_all("R7 R6 2024 to Mar");
    set_time(20, 23, 2, 28, 2, 23, 59, 59);
    step(1, 0, 0, 0); check_all("R7 2023 to Mar");
    set_time(21, 0, 2, 28, 2, 23, 59, 59);
    step(1, 0, 0, 0); check_all("R7 2100 to Mar");
    set_time(20, 0, 2, 28, 2, 23, 59, 59);
    step(1, 0, 0, 0); check_all("R7 2000 Feb29");
    set_time(20, 25, 4, 30, 4, 23, 59, 59);
    step(1, 0, 0, 0); check_all("R6 Apr30");
    set_time(99, 99, 12, 31, 1, 23, 59, 59);
    step(1, 0, 0, 0); check_all("R8 century wrap");

    set_time(20, 10, 5, 5, 5, 10, 0, 59);
    step(1, 1, 7, 8'h30);
    check_all("R2 write beats tick");

    repeat (5) step(0, 0, 0, 0);
    check_all("R11 hold");

    @(negedge clk);
    addr = 15'h1234; ram_rdata = 8'hA5; ce_n = 0; oe_n = 0; we_n = 1; #1;
    chk("R9 low rdata", rdata, 8'hA5);
    chk("R9 low ram_ce_n", {7'd0, ram_ce_n}, 8'h00);
    chk("R1 bus_oe", {7'd0, bus_oe}, 8'h01);
    addr = 15'h7FFA; #1;
    chk("R9 top ram_ce_n", {7'd0, ram_ce_n}, 8'h01);
    chk("R9 top rdata", rdata, m[2]);
    addr = 15'h0100; we_n = 0; wdata = 8'h77; oe_n = 1;
    @(posedge clk); #1;
    chk("R9 low write ram_we_n", {7'd0, ram_we_n}, 8'h00);
    ce_n = 1; we_n = 1;
    check_all("R9 low write no effect");

    for (int it = 0; it < 400; it++) begin
      bit tk = $urandom % 2;
      bit w  = ($urandom % 5) == 0;
      int a  = $urandom % 8;
      step(tk, w, 3'(a), i2b(rnd_field(a)));
      if (it % 4 == 0) check_all("R3 R4 R6 random");
      else begin
        addr = 15'($urandom % 32760); ram_rdata = 8'($urandom);
        ce_n = 0; oe_n = 0; #1;
        chk("R9 random low read", rdata, ram_rdata);
        ce_n = 1; oe_n = 1;
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule